// File: doc/BRIEF.md
# Transmit FIFO Request and Load Path

This block buffers outgoing frame bytes between a 16-bit host write port and a byte-wide MAC side. The host stores either a full word or a single byte lane per write, chosen by two byte enables. It flags the final write of each frame with an end-of-frame input, and the block tags the last byte stored by that write as the frame end. The MAC side sees the head byte and its frame-end tag together and removes them with a pop strobe.

A request output asks the host for more data. It rises when the free space reaches a selectable watermark of 16, 32 or 64 bytes, and it is held low while transmit is disabled. A write that does not fit in the remaining space is dropped whole. One cycle later the write-status output stays low, so the host can tell that the transfer failed.

Top module: `tx_load_fifo`

## Requirements
- R1: After reset the FIFO is empty (`rd_valid_o` low) and `wr_ok_o` is low.
- R2: A write with `wr_be_i` = 2'b11 stores two bytes in consecutive entries, bits 7:0 first and then bits 15:8.
- R3: With `wr_be_i` = 2'b01 only bits 7:0 are stored; with 2'b10 only bits 15:8 are stored, in one entry.
- R4: When `wr_eof_i` is high on an accepted write, the last byte that write stores carries `rd_last_o` = 1. Every other byte carries 0.
- R5: A write is accepted only if the free space covers all of its bytes. A rejected write changes no content. `wr_ok_o` is high in the cycle after an accepted write and low after a rejected one.
- R6: With transmit enabled, `req_o` is high exactly when free space is at least the watermark: `wm_sel_i` 0 gives 16 bytes, 1 gives 32, and 2 or 3 give 64.
- R7: `req_o` is low whenever `tx_en_i` is low.
- R8: Bytes leave in write order. The head byte and its tag appear on `rd_data_o` and `rd_last_o` while `rd_valid_o` is high. A pop on an empty FIFO has no effect.
- R9: A write with `wr_be_i` = 2'b00 stores nothing and leaves `wr_ok_o` low.
- R10: The FIFO holds exactly 128 bytes. At 127 bytes a word write is rejected and a byte write is accepted. At 128 bytes any write is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| wr_data_i | input | 16 | Host write data, two byte lanes |
| wr_be_i | input | 2 | Byte enables, bit 0 = lane 7:0, bit 1 = lane 15:8 |
| wr_eof_i | input | 1 | Marks the last write of a frame |
| wr_ok_o | output | 1 | High one cycle after an accepted write |
| tx_en_i | input | 1 | Transmit enable, gates the request |
| wm_sel_i | input | 2 | Watermark select: 0=16, 1=32, 2/3=64 bytes |
| req_o | output | 1 | Request for more host data |
| rd_valid_o | output | 1 | FIFO holds at least one byte |
| rd_data_o | output | 8 | Head byte |
| rd_last_o | output | 1 | Head byte ends a frame |
| rd_pop_i | input | 1 | Removes the head byte |

## Verification
A wrong write or read pointer shows up as a misordered or stale byte on `rd_data_o` at the very next pop of that entry. A wrong occupancy count shows up in two places: `req_o` flips at the wrong fill level in the same cycle the count changes, and near full `wr_ok_o` is wrong one cycle after the write that should have been accepted or rejected. The bench therefore checks `req_o` at each side of every threshold and probes the last free entries with both word and byte writes.

// File: rtl/tx_load_fifo_pkg.sv
package tx_load_fifo_pkg;
  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } tx_byte_t;

  typedef enum logic [1:0] {
    WM_X1  = 2'd0,
    WM_X2  = 2'd1,
    WM_X4  = 2'd2,
    WM_X4B = 2'd3
  } wm_sel_e;
endpackage

// File: rtl/tx_load_fifo_wr.sv
module tx_load_fifo_wr
  import tx_load_fifo_pkg::*;
#(
  parameter int FILL_W = 8
) (
  input  logic              wr_i,
  input  logic [15:0]       data_i,
  input  logic [1:0]        be_i,
  input  logic              eof_i,
  input  logic [FILL_W-1:0] free_i,
  output logic              accept_o,
  output logic [1:0]        n_push_o,
  output tx_byte_t          e0_o,
  output tx_byte_t          e1_o
);
  logic [1:0] n_req;

  always_comb begin
    n_req = 2'd0;
    e0_o  = '0;
    e1_o  = '0;
    unique case (be_i)
      2'b11: begin
        n_req = 2'd2;
        e0_o  = '{last: 1'b0,  data: data_i[7:0]};
        e1_o  = '{last: eof_i, data: data_i[15:8]};
      end
      2'b01: begin
        n_req = 2'd1;
        e0_o  = '{last: eof_i, data: data_i[7:0]};
      end
      2'b10: begin
        n_req = 2'd1;
        e0_o  = '{last: eof_i, data: data_i[15:8]};
      end
      default: n_req = 2'd0;
    endcase
  end

  // whole write must fit, otherwise nothing is stored
  assign accept_o = wr_i && (n_req != 2'd0) && (free_i >= FILL_W'(n_req));
  assign n_push_o = accept_o ? n_req : 2'd0;
endmodule

// File: rtl/tx_load_fifo_mem.sv
module tx_load_fifo_mem
  import tx_load_fifo_pkg::*;
#(
  parameter  int DEPTH  = 128,
  localparam int AW     = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        push_n_i,
  input  tx_byte_t          e0_i,
  input  tx_byte_t          e1_i,
  input  logic              pop_i,
  output tx_byte_t          head_o,
  output logic [FILL_W-1:0] fill_o
);
  tx_byte_t          mem_q [DEPTH];
  logic [AW-1:0]     wp_q, rp_q;
  logic [FILL_W-1:0] fill_q;
  logic              pop_ok;

  assign pop_ok = pop_i && (fill_q != '0);

  always_ff @(posedge clk_i) begin
    if (push_n_i != 2'd0) mem_q[wp_q] <= e0_i;
    if (push_n_i == 2'd2) mem_q[wp_q + AW'(1)] <= e1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_q + AW'(push_n_i);
      rp_q   <= rp_q + AW'(pop_ok);
      fill_q <= fill_q + FILL_W'(push_n_i) - FILL_W'(pop_ok);
    end
  end

  assign head_o = mem_q[rp_q];
  assign fill_o = fill_q;
endmodule

// File: rtl/tx_load_fifo_req.sv
module tx_load_fifo_req
  import tx_load_fifo_pkg::*;
#(
  parameter  int DEPTH   = 128,
  parameter  int WM_BASE = 16,
  localparam int FILL_W  = $clog2(DEPTH + 1)
) (
  input  logic [FILL_W-1:0] fill_i,
  input  logic              en_i,
  input  logic [1:0]        sel_i,
  output logic              req_o
);
  logic [FILL_W-1:0] free, thr;

  assign free = FILL_W'(DEPTH) - fill_i;

  always_comb begin
    unique case (wm_sel_e'(sel_i))
      WM_X1:   thr = FILL_W'(WM_BASE);
      WM_X2:   thr = FILL_W'(WM_BASE * 2);
      default: thr = FILL_W'(WM_BASE * 4);
    endcase
  end

  assign req_o = en_i && (free >= thr);
endmodule

// File: rtl/tx_load_fifo.sv
module tx_load_fifo
  import tx_load_fifo_pkg::*;
#(
  parameter  int DEPTH   = 128,
  parameter  int WM_BASE = 16,
  localparam int FILL_W  = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [15:0] wr_data_i,
  input  logic [1:0]  wr_be_i,
  input  logic        wr_eof_i,
  output logic        wr_ok_o,
  input  logic        tx_en_i,
  input  logic [1:0]  wm_sel_i,
  output logic        req_o,
  output logic        rd_valid_o,
  output logic [7:0]  rd_data_o,
  output logic        rd_last_o,
  input  logic        rd_pop_i
);
  logic [FILL_W-1:0] fill, free;
  logic              accept;
  logic [1:0]        n_push;
  tx_byte_t          e0, e1, head;
  logic              wr_ok_q;

  assign free = FILL_W'(DEPTH) - fill;

  tx_load_fifo_wr #(.FILL_W(FILL_W)) u_wr (
    .wr_i     (wr_i),
    .data_i   (wr_data_i),
    .be_i     (wr_be_i),
    .eof_i    (wr_eof_i),
    .free_i   (free),
    .accept_o (accept),
    .n_push_o (n_push),
    .e0_o     (e0),
    .e1_o     (e1)
  );

  tx_load_fifo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_n_i (n_push),
    .e0_i     (e0),
    .e1_i     (e1),
    .pop_i    (rd_pop_i),
    .head_o   (head),
    .fill_o   (fill)
  );

  tx_load_fifo_req #(.DEPTH(DEPTH), .WM_BASE(WM_BASE)) u_req (
    .fill_i (fill),
    .en_i   (tx_en_i),
    .sel_i  (wm_sel_i),
    .req_o  (req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ok_q <= 1'b0;
    else         wr_ok_q <= accept;
  end

  assign wr_ok_o    = wr_ok_q;
  assign rd_valid_o = (fill != '0);
  assign rd_data_o  = head.data;
  assign rd_last_o  = head.last;
endmodule

// File: rtl/tx_load_fifo_chk.sv
module tx_load_fifo_chk #(
  parameter int DEPTH   = 128,
  parameter int WM_BASE = 16,
  parameter int FILL_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [1:0]        wr_be_i,
  input logic              wr_ok_o,
  input logic              tx_en_i,
  input logic              req_o,
  input logic              rd_pop_i,
  input logic              rd_valid_o,
  input logic [FILL_W-1:0] fill
);
  assert_req_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !req_o);

  assert_req_room_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (DEPTH - int'(fill)) >= WM_BASE);

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(fill) <= DEPTH);

  assert_ok_needs_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> $past(wr_i));

  assert_no_enable_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_be_i == 2'b00) |=> !wr_ok_o);

  assert_empty_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pop_i && !rd_valid_o && !wr_i) |=> !rd_valid_o);
endmodule

bind tx_load_fifo tx_load_fifo_chk #(
  .DEPTH(DEPTH), .WM_BASE(WM_BASE), .FILL_W(FILL_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .wr_be_i    (wr_be_i),
  .wr_ok_o    (wr_ok_o),
  .tx_en_i    (tx_en_i),
  .req_o      (req_o),
  .rd_pop_i   (rd_pop_i),
  .rd_valid_o (rd_valid_o),
  .fill       (fill)
);

// File: tb/sim_tx_load_fifo.sv
module sim_tx_load_fifo;
  logic        clk = 1'b0;
  logic        rst_ni, wr_i, wr_eof_i, tx_en_i, rd_pop_i;
  logic [15:0] wr_data_i;
  logic [1:0]  wr_be_i, wm_sel_i;
  logic        wr_ok_o, req_o, rd_valid_o, rd_last_o;
  logic [7:0]  rd_data_o;
  int checks = 0;
  int fails  = 0;
  int idx    = 0;

  always #2 clk = ~clk;

  tx_load_fifo u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .wr_data_i(wr_data_i),
    .wr_be_i(wr_be_i), .wr_eof_i(wr_eof_i), .wr_ok_o(wr_ok_o),
    .tx_en_i(tx_en_i), .wm_sel_i(wm_sel_i), .req_o(req_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_last_o(rd_last_o),
    .rd_pop_i(rd_pop_i)
  );

  // {be[1:0], eof, data[15:0], expected ok}
  localparam logic [19:0] VEC [5] = '{
    {2'b11, 1'b0, 16'hA1B2, 1'b1},  // R2
    {2'b01, 1'b0, 16'h99C3, 1'b1},  // R3 low lane
    {2'b10, 1'b1, 16'hD488, 1'b1},  // R3 high lane, R4
    {2'b00, 1'b1, 16'hFFFF, 1'b0},  // R9
    {2'b11, 1'b1, 16'h2211, 1'b1}   // R2, R4
  };
  // {last, data} in pop order
  localparam logic [8:0] EXP [6] = '{
    9'h0B2, 9'h0A1, 9'h0C3, 9'h1D4, 9'h011, 9'h122
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] be, input logic eof, input logic [15:0] d,
                          input logic exp_ok, input string req);
    @(negedge clk);
    wr_i = 1'b1; wr_be_i = be; wr_eof_i = eof; wr_data_i = d;
    @(negedge clk);
    wr_i = 1'b0; wr_be_i = 2'b00; wr_eof_i = 1'b0;
    chk(req, 32'(wr_ok_o), 32'(exp_ok));
  endtask

  task automatic wr_byte(input logic exp_ok, input string req);
    do_write(2'b01, 1'b0, {8'h00, 8'(idx)}, exp_ok, req);
    if (exp_ok) idx++;
  endtask

  task automatic do_pop(input logic [8:0] exp, input string req);
    @(negedge clk);
    chk(req, {22'd0, rd_valid_o, rd_last_o, rd_data_o}, {22'd0, 1'b1, exp});
    rd_pop_i = 1'b1;
    @(negedge clk);
    rd_pop_i = 1'b0;
  endtask

  task automatic req_chk(input logic [1:0] sel, input logic exp, input string req);
    wm_sel_i = sel;
    #1;
    chk(req, 32'(req_o), 32'(exp));
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wr_i = 1'b0; wr_eof_i = 1'b0; tx_en_i = 1'b0; rd_pop_i = 1'b0;
    wr_data_i = '0; wr_be_i = '0; wm_sel_i = 2'd0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid", 32'(rd_valid_o), 32'd0);
    chk("R1 ok", 32'(wr_ok_o), 32'd0);
    chk("R7 disabled", 32'(req_o), 32'd0);
    tx_en_i = 1'b1;
    req_chk(2'd0, 1'b1, "R6 empty");

    for (int i = 0; i < 5; i++)
      do_write(VEC[i][19:18], VEC[i][17], VEC[i][16:1], VEC[i][0], "R2 R3 R9 write");
    for (int i = 0; i < 6; i++)
      do_pop(EXP[i], "R2 R3 R4 R8 order");

    @(negedge clk);
    rd_pop_i = 1'b1;
    @(negedge clk);
    rd_pop_i = 1'b0;
    chk("R8 empty pop", 32'(rd_valid_o), 32'd0);

    repeat (64) wr_byte(1'b1, "R5");
    req_chk(2'd2, 1'b1, "R6 sel2 free64");
    req_chk(2'd3, 1'b1, "R6 sel3 free64");
    tx_en_i = 1'b0;
    req_chk(2'd2, 1'b0, "R7 gated");
    tx_en_i = 1'b1;
    wr_byte(1'b1, "R5");
    req_chk(2'd2, 1'b0, "R6 sel2 free63");
    req_chk(2'd3, 1'b0, "R6 sel3 free63");
    repeat (31) wr_byte(1'b1, "R5");
    req_chk(2'd1, 1'b1, "R6 sel1 free32");
    wr_byte(1'b1, "R5");
    req_chk(2'd1, 1'b0, "R6 sel1 free31");
    repeat (15) wr_byte(1'b1, "R5");
    req_chk(2'd0, 1'b1, "R6 sel0 free16");
    wr_byte(1'b1, "R5");
    req_chk(2'd0, 1'b0, "R6 sel0 free15");
    repeat (14) wr_byte(1'b1, "R5");

    do_write(2'b11, 1'b0, 16'hEEEE, 1'b0, "R10 word at 127");
    do_write(2'b10, 1'b0, {8'(idx), 8'h55}, 1'b1, "R10 byte at 127 R3");
    idx++;
    wr_byte(1'b0, "R10 full");

    for (int i = 0; i < 128; i++)
      do_pop({1'b0, 8'(i)}, "R10 R5 drain");
    @(negedge clk);
    chk("R8 drained", 32'(rd_valid_o), 32'd0);
    req_chk(2'd2, 1'b1, "R6 drained");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule